// File: doc/BRIEF.md
# Write Window Block Mark Tracker

This block follows which protocol blocks of the active flash write window have been modified or erased by the host. It keeps one mark per block: clean, dirty or erased. The host side feeds it range commands, each an offset and a count in blocks counted from the first block of the window. A range that would run past the end of the window is refused and changes nothing. While a window is open, a byte address inside the window is looked up combinationally, and a flag tells the read path to return 0xFF when that block carries an erased mark.

A flush walks the marked blocks from the lowest index upward. For each one it raises a request to an external writer, naming the block and whether it is erased or dirty, and holds the request until the writer acknowledges it. A clean acknowledge clears that block's mark. An error acknowledge stops the walk, and every mark not yet written stays in place. Closing a window, or opening a new one while a window is active, first runs the same flush and then empties the map, so no mark outlives its window. Block size is a power of two of at least 4 KiB, set as a shift. The map holds up to 64 blocks.

Top module: `wwin_mark_tracker`

## Requirements
- R1: A mark command whose offset plus count exceeds the window size in blocks completes with status 1 (range) and leaves every mark unchanged. A range ending exactly at the window end is accepted with status 0.
- R2: Block indices count from the window's first block, which is index 0. A mark command covers blocks offset through offset+count-1. The read lookup takes its block index from `rd_addr` bits above `BLK_SHIFT`.
- R3: `rd_force_ff` is high exactly when the addressed block carries an erased mark. A later mark command replaces an earlier mark on the same block, so a dirty mark over an erased block drops the flag.
- R4: A successful flush issues one `wr_req` per marked block in ascending index order. `wr_erase` is 1 for erased blocks and 0 for dirty ones. The request is held with a stable `wr_idx` until `wr_ack`. An acknowledged block becomes clean. The operation then ends with `op_done` and status 0. With nothing marked it ends two cycles after the request and issues no writes.
- R5: `wr_ack` together with `wr_err` ends the flush with status 2 (write error). The failing block and all later blocks keep their marks, and a following flush writes them.
- R6: Closing an active window flushes it, then clears all marks and drops `win_active`. This holds even when the flush fails, in which case status 2 is reported.
- R7: Opening a window while one is active flushes the old window. The new window then opens with its own size and an empty map.
- R8: An open request with size 0 or larger than `MAX_BLK` completes with status 1 and leaves no active window. When a window was active, it is still flushed and closed first.
- R9: A mark, flush or close with no active window completes with status 3 (no window). A mark command that arrives during a flush completes with status 4 (busy) and marks nothing.
- R10: After reset there is no active window and the map is empty. `wr_req`, `mk_done`, `op_done` and `rd_force_ff` are low.
- R11: `mk_done` and `mk_status` are valid in the cycle right after `mk_valid` is sampled. An open with no window already active reports `op_done` in the cycle right after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_req | input | 1 | Open a write window of `open_size` blocks (pulse) |
| close_req | input | 1 | Close the active window (pulse) |
| flush_req | input | 1 | Flush the marked blocks (pulse) |
| open_size | input | 16 | Requested window size in blocks |
| mk_valid | input | 1 | Mark command strobe |
| mk_erase | input | 1 | 1 marks the range erased, 0 marks it dirty |
| mk_off | input | 16 | First block of the range, relative to the window |
| mk_cnt | input | 16 | Number of blocks in the range |
| mk_done | output | 1 | Mark command completed |
| mk_status | output | 3 | 0 ok, 1 range, 3 no window, 4 busy |
| op_done | output | 1 | Open, close or flush completed |
| op_status | output | 3 | 0 ok, 1 range, 2 write error, 3 no window |
| win_active | output | 1 | A write window is open |
| wr_req | output | 1 | Block write-back request to the writer |
| wr_idx | output | 6 | Block index of the request |
| wr_erase | output | 1 | Requested block is erased (1) or dirty (0) |
| wr_ack | input | 1 | Writer finished the requested block |
| wr_err | input | 1 | Writer failed, qualified by `wr_ack` |
| rd_addr | input | 18 | Byte address within the window for read lookup |
| rd_force_ff | output | 1 | Return 0xFF for this read |

## Verification
Mark results are registered once, so the bench samples `mk_done` and `mk_status` one nanosecond after the edge that takes `mk_valid` and expects them there and nowhere else. The read flag is combinational from the map, so it is checked in the same low clock phase that `rd_addr` changes, after a mark has landed. Open with no prior window must answer after exactly one edge and an empty flush after exactly two. Flushes that do real work take a data-dependent number of cycles, so the bench waits for `op_done` but compares each writer request against a queue of expected blocks at the moment it appears. While the acknowledge is delayed, it also checks every cycle that the request holds steady.

// File: rtl/wwin_pkg.sv
package wwin_pkg;

  typedef enum logic [1:0] {
    MK_CLEAN  = 2'd0,
    MK_DIRTY  = 2'd1,
    MK_ERASED = 2'd2
  } mark_e;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_RANGE = 3'd1,
    ST_WRERR = 3'd2,
    ST_NOWIN = 3'd3,
    ST_BUSY  = 3'd4
  } stat_e;

  typedef enum logic [1:0] {
    OP_FLUSH  = 2'd0,
    OP_CLOSE  = 2'd1,
    OP_REOPEN = 2'd2
  } op_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WALK = 1'b1
  } fsm_e;

endpackage

// File: rtl/wwin_range_chk.sv
module wwin_range_chk #(
  parameter int FLD_W = 16,
  parameter int CNT_W = 7
) (
  input  logic [FLD_W-1:0] off,
  input  logic [FLD_W-1:0] cnt,
  input  logic [CNT_W-1:0] win_blocks,
  output logic [FLD_W:0]   hi_excl,
  output logic             fits
);
  localparam int LIM_W = FLD_W + 1;

  always_comb begin
    hi_excl = {1'b0, off} + {1'b0, cnt};
    fits    = (hi_excl <= LIM_W'(win_blocks));
  end
endmodule

// File: rtl/wwin_first_set.sv
module wwin_first_set #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wwin_mark_map.sv
module wwin_mark_map
  import wwin_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int LIM_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             set_erase,
  input  logic [LIM_W-1:0] set_lo,
  input  logic [LIM_W-1:0] set_hi,
  input  logic             clr_one,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  output logic [N-1:0]     marked,
  output logic [N-1:0]     erased
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    mark_e cell_q, cell_d;
    logic  in_rng;

    always_comb begin
      in_rng = (LIM_W'(i) >= set_lo) && (LIM_W'(i) < set_hi);
      cell_d = cell_q;
      if (clr_all) begin
        cell_d = MK_CLEAN;
      end else if (clr_one && (clr_idx == IDX_W'(i))) begin
        cell_d = MK_CLEAN;
      end else if (set_en && in_rng) begin
        cell_d = set_erase ? MK_ERASED : MK_DIRTY;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= MK_CLEAN;
      else        cell_q <= cell_d;
    end

    assign marked[i] = (cell_q != MK_CLEAN);
    assign erased[i] = (cell_q == MK_ERASED);
  end

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (marked == '0));

endmodule

// File: rtl/wwin_mark_tracker.sv
module wwin_mark_tracker
  import wwin_pkg::*;
#(
  parameter int MAX_BLK   = 64,
  parameter int BLK_SHIFT = 12,
  parameter int FLD_W     = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 open_req,
  input  logic                                 close_req,
  input  logic                                 flush_req,
  input  logic [FLD_W-1:0]                     open_size,
  input  logic                                 mk_valid,
  input  logic                                 mk_erase,
  input  logic [FLD_W-1:0]                     mk_off,
  input  logic [FLD_W-1:0]                     mk_cnt,
  output logic                                 mk_done,
  output logic [2:0]                           mk_status,
  output logic                                 op_done,
  output logic [2:0]                           op_status,
  output logic                                 win_active,
  output logic                                 wr_req,
  output logic [$clog2(MAX_BLK)-1:0]           wr_idx,
  output logic                                 wr_erase,
  input  logic                                 wr_ack,
  input  logic                                 wr_err,
  input  logic [$clog2(MAX_BLK)+BLK_SHIFT-1:0] rd_addr,
  output logic                                 rd_force_ff
);

  localparam int IDX_W = $clog2(MAX_BLK);
  localparam int CNT_W = IDX_W + 1;
  localparam int RA_W  = IDX_W + BLK_SHIFT;
  localparam int LIM_W = FLD_W + 1;

  // state
  fsm_e             fsm_q, fsm_d;
  logic             act_q, act_d;
  logic [CNT_W-1:0] size_q, size_d;
  op_e              pk_q, pk_d;
  logic [CNT_W-1:0] psize_q, psize_d;
  logic             pok_q, pok_d;
  logic             mkd_q, mkd_d;
  stat_e            mks_q, mks_d;
  logic             opd_q, opd_d;
  stat_e            ops_q, ops_d;

  // map control
  logic             set_en, clr_one, clr_all;
  logic [LIM_W-1:0] hi_excl;
  logic             fits;
  logic [MAX_BLK-1:0] marked_v, erased_v;
  logic             found;
  logic [IDX_W-1:0] first_idx;
  logic             open_ok;
  logic             fin, fin_err;

  wwin_range_chk #(.FLD_W(FLD_W), .CNT_W(CNT_W)) u_rng (
    .off(mk_off), .cnt(mk_cnt), .win_blocks(size_q),
    .hi_excl(hi_excl), .fits(fits)
  );

  wwin_mark_map #(.N(MAX_BLK), .IDX_W(IDX_W), .LIM_W(LIM_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_erase(mk_erase),
    .set_lo({1'b0, mk_off}), .set_hi(hi_excl),
    .clr_one(clr_one), .clr_idx(first_idx), .clr_all(clr_all),
    .marked(marked_v), .erased(erased_v)
  );

  wwin_first_set #(.N(MAX_BLK), .IDX_W(IDX_W)) u_first (
    .vec(marked_v), .found(found), .idx(first_idx)
  );

  assign open_ok = (open_size != '0) && (open_size <= FLD_W'(MAX_BLK));

  // next-state
  always_comb begin
    fsm_d   = fsm_q;
    act_d   = act_q;
    size_d  = size_q;
    pk_d    = pk_q;
    psize_d = psize_q;
    pok_d   = pok_q;
    mkd_d   = 1'b0;
    mks_d   = mks_q;
    opd_d   = 1'b0;
    ops_d   = ops_q;
    set_en  = 1'b0;
    clr_one = 1'b0;
    clr_all = 1'b0;
    fin     = 1'b0;
    fin_err = 1'b0;

    // range commands
    if (mk_valid) begin
      mkd_d = 1'b1;
      if (fsm_q == FS_WALK)  mks_d = ST_BUSY;
      else if (!act_q)       mks_d = ST_NOWIN;
      else if (!fits)        mks_d = ST_RANGE;
      else begin
        mks_d  = ST_OK;
        set_en = 1'b1;
      end
    end

    // window operations
    if (fsm_q == FS_IDLE) begin
      if (open_req) begin
        if (act_q) begin
          fsm_d   = FS_WALK;
          pk_d    = OP_REOPEN;
          psize_d = open_size[CNT_W-1:0];
          pok_d   = open_ok;
        end else begin
          opd_d   = 1'b1;
          ops_d   = open_ok ? ST_OK : ST_RANGE;
          act_d   = open_ok;
          size_d  = open_ok ? open_size[CNT_W-1:0] : '0;
          clr_all = 1'b1;
        end
      end else if (close_req) begin
        if (act_q) begin
          fsm_d = FS_WALK;
          pk_d  = OP_CLOSE;
        end else begin
          opd_d = 1'b1;
          ops_d = ST_NOWIN;
        end
      end else if (flush_req) begin
        if (act_q) begin
          fsm_d = FS_WALK;
          pk_d  = OP_FLUSH;
        end else begin
          opd_d = 1'b1;
          ops_d = ST_NOWIN;
        end
      end
    end else begin
      if (!found) begin
        fin = 1'b1;
      end else if (wr_ack) begin
        if (wr_err) begin
          fin     = 1'b1;
          fin_err = 1'b1;
        end else begin
          clr_one = 1'b1;
        end
      end
    end

    if (fin) begin
      fsm_d = FS_IDLE;
      opd_d = 1'b1;
      if (fin_err)                         ops_d = ST_WRERR;
      else if (pk_q == OP_REOPEN && !pok_q) ops_d = ST_RANGE;
      else                                  ops_d = ST_OK;
      if (pk_q != OP_FLUSH) begin
        clr_all = 1'b1;
        act_d   = (pk_q == OP_REOPEN) && pok_q && !fin_err;
        size_d  = ((pk_q == OP_REOPEN) && pok_q && !fin_err) ? psize_q : '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q   <= FS_IDLE;
      act_q   <= 1'b0;
      size_q  <= '0;
      pk_q    <= OP_FLUSH;
      psize_q <= '0;
      pok_q   <= 1'b0;
      mkd_q   <= 1'b0;
      mks_q   <= ST_OK;
      opd_q   <= 1'b0;
      ops_q   <= ST_OK;
    end else begin
      fsm_q <= fsm_d;
      act_q <= act_d;
      mkd_q <= mkd_d;
      opd_q <= opd_d;
      if (mkd_d) mks_q <= mks_d;
      if (opd_d) ops_q <= ops_d;
      if (fsm_q == FS_IDLE) begin
        pk_q    <= pk_d;
        psize_q <= psize_d;
        pok_q   <= pok_d;
      end
      if (act_d != act_q || size_d != size_q) size_q <= size_d;
    end
  end

  // outputs
  assign mk_done     = mkd_q;
  assign mk_status   = mks_q;
  assign op_done     = opd_q;
  assign op_status   = ops_q;
  assign win_active  = act_q;
  assign wr_req      = (fsm_q == FS_WALK) && found;
  assign wr_idx      = first_idx;
  assign wr_erase    = erased_v[first_idx];
  assign rd_force_ff = act_q && erased_v[rd_addr[RA_W-1:BLK_SHIFT]];

  // assertions
  assert_range_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_done && mk_status == ST_RANGE) |-> $stable(marked_v));

  assert_outside_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ((marked_v >> size_q) == '0));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_idx)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && !wr_err) |=>
      ((marked_v & (MAX_BLK'(1) << $past(wr_idx))) == '0));

  assert_err_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ack && wr_err && pk_q == OP_FLUSH) |=> $stable(marked_v));

  assert_closed_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && fsm_q == FS_IDLE) |-> (marked_v == '0));

  assert_mk_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mk_valid |=> mk_done);

endmodule

// File: tb/sim_wwin_mark_tracker.sv
module sim_wwin_mark_tracker;

  localparam int IDX_W = 6;
  localparam int RA_W  = 18;
  localparam int BSH   = 12;

  logic              clk, rst_n;
  logic              open_req, close_req, flush_req;
  logic [15:0]       open_size;
  logic              mk_valid, mk_erase;
  logic [15:0]       mk_off, mk_cnt;
  logic              mk_done, op_done, win_active;
  logic [2:0]        mk_status, op_status;
  logic              wr_req, wr_erase, wr_ack, wr_err;
  logic [IDX_W-1:0]  wr_idx;
  logic [RA_W-1:0]   rd_addr;
  logic              rd_force_ff;

  wwin_mark_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .open_req(open_req), .close_req(close_req), .flush_req(flush_req),
    .open_size(open_size),
    .mk_valid(mk_valid), .mk_erase(mk_erase), .mk_off(mk_off), .mk_cnt(mk_cnt),
    .mk_done(mk_done), .mk_status(mk_status),
    .op_done(op_done), .op_status(op_status), .win_active(win_active),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_erase(wr_erase),
    .wr_ack(wr_ack), .wr_err(wr_err),
    .rd_addr(rd_addr), .rd_force_ff(rd_force_ff)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int idx; bit er; } wr_item_t;
  wr_item_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int err_idx = -1;
  int ack_delay = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int idx, input bit er);
    wr_item_t it;
    it.idx = idx;
    it.er  = er;
    exp_q.push_back(it);
  endtask

  // writer model and scoreboard monitor
  initial begin
    wr_ack = 1'b0;
    wr_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && wr_req) begin
        int hold;
        hold = int'(wr_idx);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected write request", int'(wr_idx), -1);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          check(int'(wr_idx) == e.idx, "R4 write order index", int'(wr_idx), e.idx);
          check(wr_erase == e.er, "R4 write erase flag", int'(wr_erase), int'(e.er));
        end
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          check(wr_req && int'(wr_idx) == hold, "R4 request held", int'(wr_idx), hold);
        end
        wr_ack = 1'b1;
        wr_err = (int'(wr_idx) == err_idx);
        @(posedge clk);
        #1;
        wr_ack = 1'b0;
        wr_err = 1'b0;
      end
    end
  end

  task automatic mk(input bit er, input int off, input int cnt, input int exp, input string tag);
    @(negedge clk);
    mk_valid = 1'b1;
    mk_erase = er;
    mk_off   = 16'(off);
    mk_cnt   = 16'(cnt);
    @(posedge clk);
    #1;
    mk_valid = 1'b0;
    check(mk_done == 1'b1, {tag, " done"}, int'(mk_done), 1);
    check(int'(mk_status) == exp, {tag, " status"}, int'(mk_status), exp);
  endtask

  // kind: 0 open, 1 close, 2 flush
  task automatic op_start(input int kind, input int size);
    @(negedge clk);
    open_req  = (kind == 0);
    close_req = (kind == 1);
    flush_req = (kind == 2);
    open_size = 16'(size);
    @(posedge clk);
    #1;
    open_req  = 1'b0;
    close_req = 1'b0;
    flush_req = 1'b0;
  endtask

  task automatic op_wait(input int exp, input string tag, output int lat);
    lat = 1;
    while (!op_done && lat < 3000) begin
      @(posedge clk);
      #1;
      lat++;
    end
    check(op_done == 1'b1, {tag, " op done"}, int'(op_done), 1);
    check(int'(op_status) == exp, {tag, " op status"}, int'(op_status), exp);
    check(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
  endtask

  task automatic op(input int kind, input int size, input int exp, input string tag);
    int lat;
    op_start(kind, size);
    op_wait(exp, tag, lat);
  endtask

  task automatic rd(input int blk, input int byte_off, input bit exp, input string tag);
    @(negedge clk);
    rd_addr = RA_W'((blk << BSH) + byte_off);
    #1;
    check(rd_force_ff == exp, tag, int'(rd_force_ff), int'(exp));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    rst_n = 1'b0;
    open_req = 1'b0; close_req = 1'b0; flush_req = 1'b0; open_size = '0;
    mk_valid = 1'b0; mk_erase = 1'b0; mk_off = '0; mk_cnt = '0;
    rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check(win_active == 1'b0, "R10 reset win_active", int'(win_active), 0);
    check(wr_req == 1'b0, "R10 reset wr_req", int'(wr_req), 0);
    check(mk_done == 1'b0 && op_done == 1'b0, "R10 reset done", int'(mk_done | op_done), 0);
    check(rd_force_ff == 1'b0, "R10 reset rd_force_ff", int'(rd_force_ff), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9 no window
    mk(1'b0, 0, 1, 3, "R9 mark without window");
    op(2, 0, 3, "R9 flush without window");
    op(1, 0, 3, "R9 close without window");

    // R8 bad open sizes
    op(0, 0, 1, "R8 open size zero");
    check(win_active == 1'b0, "R8 not active after size zero", int'(win_active), 0);
    op(0, 65, 1, "R8 open size too big");
    check(win_active == 1'b0, "R8 not active after oversize", int'(win_active), 0);

    // R11 open latency
    op_start(0, 8);
    op_wait(0, "R11 open 8", lat);
    check(lat == 1, "R11 open latency", lat, 1);
    check(win_active == 1'b1, "R11 window active", int'(win_active), 1);

    // R1 range checks
    mk(1'b1, 6, 3, 1, "R1 past window end");
    rd(6, 0, 1'b0, "R1 block 6 untouched");
    rd(7, 0, 1'b0, "R1 block 7 untouched");
    mk(1'b1, 6, 2, 0, "R1 range ending at window end");
    rd(7, 12, 1'b1, "R3 block 7 erased");
    rd(5, 0, 1'b0, "R2 block 5 below range clean");
    mk(1'b0, 1, 2, 0, "R2 dirty 1..2");
    mk(1'b0, 7, 1, 0, "R3 dirty over erased");
    rd(7, 0, 1'b0, "R3 dirty replaces erased");
    rd(6, 4095, 1'b1, "R3 block 6 still erased");
    mk(1'b1, 0, 1, 0, "R2 erase block 0");
    rd(0, 12'hABC, 1'b1, "R2 block 0 from window start");
    rd(1, 0, 1'b0, "R3 dirty block reads normally");

    // R4 flush with slow writer, R9 busy during flush
    ack_delay = 3;
    push(0, 1'b1); push(1, 1'b0); push(2, 1'b0); push(6, 1'b1); push(7, 1'b0);
    op_start(2, 0);
    mk(1'b1, 3, 1, 4, "R9 mark during flush busy");
    op_wait(0, "R4 flush", lat);
    rd(0, 0, 1'b0, "R4 marks cleared after flush");
    rd(3, 0, 1'b0, "R9 busy mark not applied");
    ack_delay = 0;

    // R4 empty flush
    op_start(2, 0);
    op_wait(0, "R4 empty flush", lat);
    check(lat == 2, "R4 empty flush latency", lat, 2);

    // R5 writer error keeps marks
    mk(1'b0, 2, 3, 0, "R5 dirty 2..4");
    mk(1'b1, 5, 1, 0, "R5 erase 5");
    err_idx = 3;
    push(2, 1'b0); push(3, 1'b0);
    op(2, 0, 2, "R5 flush error");
    err_idx = -1;
    rd(5, 0, 1'b1, "R5 erased mark kept");
    check(win_active == 1'b1, "R5 window stays open", int'(win_active), 1);
    push(3, 1'b0); push(4, 1'b0); push(5, 1'b1);
    op(2, 0, 0, "R5 retry flush");

    // R7 reopen while active
    mk(1'b1, 0, 2, 0, "R7 erase 0..1");
    push(0, 1'b1); push(1, 1'b1);
    op(0, 4, 0, "R7 reopen");
    check(win_active == 1'b1, "R7 new window active", int'(win_active), 1);
    rd(0, 0, 1'b0, "R7 map empty after reopen");
    mk(1'b0, 3, 2, 1, "R7 new size enforced");
    mk(1'b0, 3, 1, 0, "R7 dirty last block");

    // R6 close with write error
    err_idx = 3;
    mk(1'b1, 2, 1, 0, "R6 erase block 2");
    push(2, 1'b1); push(3, 1'b0);
    op(1, 0, 2, "R6 close with error");
    err_idx = -1;
    check(win_active == 1'b0, "R6 closed", int'(win_active), 0);
    rd(2, 0, 1'b0, "R6 marks gone after close");
    mk(1'b0, 0, 1, 3, "R6 mark after close");

    // full-size window, last block
    op(0, 64, 0, "R2 open 64");
    mk(1'b1, 63, 1, 0, "R2 erase last block");
    rd(63, 7, 1'b1, "R2 last block erased");
    mk(1'b1, 63, 2, 1, "R1 past 64-block end");
    push(63, 1'b1);
    op(1, 0, 0, "R6 close ok");
    check(win_active == 1'b0, "R6 closed ok", int'(win_active), 0);

    // R8 reopen with bad size while active
    op(0, 4, 0, "R8 open 4");
    mk(1'b0, 0, 1, 0, "R8 dirty 0");
    push(0, 1'b0);
    op(0, 0, 1, "R8 reopen size zero");
    check(win_active == 1'b0, "R8 no window after bad reopen", int'(win_active), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule